// File: doc/BRIEF.md
# Conversion Synchronization Monitor

This block watches whether the converter's output timing stays phase-locked to an external periodic SYNC pulse. It runs on the master clock and starts counting master-clock cycles when data-ready is asserted. When the next rising edge of SYNC arrives, the count is taken as one measurement. The first measurement after the monitor is enabled becomes the reference. Every later measurement is compared with that reference, and a difference of up to one cycle in either direction still counts as locked.

When a measurement falls outside that window, the block sets a sticky loss flag and adopts the failing measurement as the new reference. The flag stays set until a status-read strobe clears it. The block only reports the loss; realigning the converter is left to other logic.

The monitor runs only when sync mode and external-clock mode are both selected and both shared pins are in their dedicated SYNC and clock roles. SYNC is asynchronous to the master clock. It passes through a synchronizer before edge detection, so every measurement carries the same fixed offset.

Top module: `sync_lock_monitor`

## Requirements
- R1: The monitor is active only when `sync_mode_en`=1, `ext_clk_en`=1, `pin_a_gpio_en`=0 and `pin_b_gpio_en`=0. While inactive, no measurement is taken, the reference is discarded, and `in_sync` and `sync_lost` read 0.
- R2: With the default two-stage synchronizer, data-ready is sampled at clock edge 0. If SYNC rises so that it meets setup for edge K (K ≥ 1), the measurement is K+2 cycles.
- R3: The first measurement after reset or after becoming active is stored as the reference, and `in_sync` goes to 1.
- R4: `last_count` takes the value of every completed measurement one cycle after it completes. Otherwise it holds its value.
- R5: A measurement within one cycle of the reference, above or below, leaves `sync_lost` at 0, `in_sync` at 1 and the reference unchanged.
- R6: A measurement that differs from the reference by more than one cycle, above or below, sets `sync_lost` to 1 and `in_sync` to 0. That measurement becomes the new reference.
- R7: `sync_lost` is sticky and is cleared only by `status_rd`. If a new loss occurs in the same cycle as the read, the loss wins.
- R8: The cycle counter stops at 2^CNT_W−1 and does not wrap.
- R9: A SYNC rising edge with no data-ready assertion since the previous measurement produces no measurement. `last_count` and the status outputs are unchanged.
- R10: If data-ready is asserted more than once before a SYNC edge, the count restarts from the most recent assertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode_en | input | 1 | Sync-mode select |
| ext_clk_en | input | 1 | External-clock-mode select |
| pin_a_gpio_en | input | 1 | Shared SYNC pin in general-purpose role (must be 0) |
| pin_b_gpio_en | input | 1 | Shared clock pin in general-purpose role (must be 0) |
| rdy_strobe | input | 1 | One-cycle pulse when conversion data becomes ready |
| sync_pin | input | 1 | Asynchronous external SYNC pulse |
| status_rd | input | 1 | Status-read strobe that clears the loss flag |
| in_sync | output | 1 | Reference held and no loss flagged |
| sync_lost | output | 1 | Sticky loss-of-sync flag |
| last_count | output | CNT_W | Most recent measurement in master-clock cycles |

## Verification
The bound checker watches the following on every cycle:
- the counter steps by one, or stays at its ceiling;
- `last_count` moves only when a measurement completes;
- the first measurement becomes the reference;
- the loss flag stays set until a read clears it;
- both status outputs read 0 while the monitor is inactive.

Only the bench scenarios can show:
- the exact count for a known phase through the synchronizer;
- the one-cycle tolerance in both directions;
- replacement of the reference after a loss;
- counting from the most recent of several data-ready pulses;
- that a SYNC edge with no preceding data-ready is ignored.

// File: rtl/syncmon_pkg.sv
package syncmon_pkg;

   typedef struct packed {
      logic sync_mode;
      logic ext_clk;
      logic pin_a_gpio;
      logic pin_b_gpio;
   } mon_cfg_t;

   function automatic logic cfg_active(input mon_cfg_t c);
      return c.sync_mode & c.ext_clk & ~c.pin_a_gpio & ~c.pin_b_gpio;
   endfunction

endpackage

// File: rtl/syncmon_edge_sync.sv
module syncmon_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   localparam int LAST = STAGES;

   logic [LAST:0] pipe;

   generate
      for (genvar i = 0; i <= LAST; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[0] <= 1'b0;
               else        pipe[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[i] <= 1'b0;
               else        pipe[i] <= pipe[i-1];
            end
         end
      end
   endgenerate

   // rising edge seen at the output of the last synchronizing stage
   assign rise = pipe[LAST-1] & ~pipe[LAST];
endmodule

// File: rtl/syncmon_phase_counter.sv
module syncmon_phase_counter #(
   parameter int CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             rdy,
   input  logic             rise,
   output logic             armed,
   output logic [CNT_W-1:0] count,
   output logic             meas_done,
   output logic [CNT_W-1:0] meas_value
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   // a measurement closes on a SYNC edge only if data-ready armed the counter
   assign meas_done  = active & armed & rise;
   assign meas_value = count;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         count <= '0;
      end else if (!active) begin
         armed <= 1'b0;
         count <= '0;
      end else if (rdy) begin
         // newest data-ready restarts the phase count
         armed <= 1'b1;
         count <= CNT_W'(1);
      end else if (meas_done) begin
         armed <= 1'b0;
      end else if (armed && count != CNT_MAX) begin
         count <= count + CNT_W'(1);
      end
   end
endmodule

// File: rtl/syncmon_lock_eval.sv
module syncmon_lock_eval #(
   parameter int CNT_W = 20,
   parameter int TOL   = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             meas_done,
   input  logic [CNT_W-1:0] meas_value,
   input  logic             status_rd,
   output logic             ref_valid,
   output logic             sync_lost,
   output logic [CNT_W-1:0] last_count
);
   localparam logic [CNT_W-1:0] TOL_V = CNT_W'(TOL);

   logic [CNT_W-1:0] ref_count;
   logic [CNT_W-1:0] delta;
   logic             out_of_win;

   assign delta = (meas_value >= ref_count) ? (meas_value - ref_count)
                                            : (ref_count - meas_value);

   generate
      if (TOL == 0) begin : g_exact
         assign out_of_win = (meas_value != ref_count);
      end else begin : g_window
         assign out_of_win = (delta > TOL_V);
      end
   endgenerate

   logic new_loss;
   assign new_loss = meas_done & ref_valid & out_of_win;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_valid  <= 1'b0;
         ref_count  <= '0;
         last_count <= '0;
      end else if (!active) begin
         ref_valid  <= 1'b0;
      end else if (meas_done) begin
         last_count <= meas_value;
         if (!ref_valid || out_of_win) begin
            ref_count <= meas_value;
            ref_valid <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sync_lost <= 1'b0;
      else if (!active)   sync_lost <= 1'b0;
      else if (new_loss)  sync_lost <= 1'b1;
      else if (status_rd) sync_lost <= 1'b0;
   end
endmodule

// File: rtl/sync_lock_monitor.sv
module sync_lock_monitor
   import syncmon_pkg::*;
#(
   parameter int CNT_W       = 20,
   parameter int SYNC_STAGES = 2,
   parameter int TOL         = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_mode_en,
   input  logic             ext_clk_en,
   input  logic             pin_a_gpio_en,
   input  logic             pin_b_gpio_en,
   input  logic             rdy_strobe,
   input  logic             sync_pin,
   input  logic             status_rd,
   output logic             in_sync,
   output logic             sync_lost,
   output logic [CNT_W-1:0] last_count
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("CNT_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("SYNC_STAGES must be at least 2");
      end
      if (TOL < 0 || TOL >= (1 << (CNT_W - 1))) begin : g_bad_tol
         $error("TOL out of range for CNT_W");
      end
   endgenerate

   mon_cfg_t         cfg;
   logic             active;
   logic             sync_rise;
   logic             armed;
   logic [CNT_W-1:0] cnt_val;
   logic             meas_done;
   logic [CNT_W-1:0] meas_val;
   logic             ref_valid;

   assign cfg    = '{sync_mode: sync_mode_en, ext_clk: ext_clk_en,
                     pin_a_gpio: pin_a_gpio_en, pin_b_gpio: pin_b_gpio_en};
   assign active = cfg_active(cfg);

   syncmon_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (sync_pin),
      .rise     (sync_rise)
   );

   syncmon_phase_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .active     (active),
      .rdy        (rdy_strobe),
      .rise       (sync_rise),
      .armed      (armed),
      .count      (cnt_val),
      .meas_done  (meas_done),
      .meas_value (meas_val)
   );

   syncmon_lock_eval #(.CNT_W(CNT_W), .TOL(TOL)) u_eval (
      .clk        (clk),
      .rst_n      (rst_n),
      .active     (active),
      .meas_done  (meas_done),
      .meas_value (meas_val),
      .status_rd  (status_rd),
      .ref_valid  (ref_valid),
      .sync_lost  (sync_lost),
      .last_count (last_count)
   );

   assign in_sync = ref_valid & ~sync_lost;
endmodule

// File: rtl/syncmon_checker.sv
module syncmon_checker #(
   parameter int CNT_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sync_mode_en,
   input logic             ext_clk_en,
   input logic             pin_a_gpio_en,
   input logic             pin_b_gpio_en,
   input logic             rdy_strobe,
   input logic             status_rd,
   input logic             in_sync,
   input logic             sync_lost,
   input logic [CNT_W-1:0] last_count,
   input logic             armed,
   input logic [CNT_W-1:0] cnt_val,
   input logic             meas_done,
   input logic [CNT_W-1:0] meas_val,
   input logic             ref_valid
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   logic on;
   assign on = sync_mode_en & ext_clk_en & ~pin_a_gpio_en & ~pin_b_gpio_en;

   a_r1_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !on |=> (!in_sync && !sync_lost));

   a_r2_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (on && armed && !rdy_strobe && !meas_done && cnt_val != CMAX)
      |=> cnt_val == CNT_W'($past(cnt_val) + CNT_W'(1)));

   a_r8_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      (on && armed && !rdy_strobe && !meas_done && cnt_val == CMAX)
      |=> cnt_val == CMAX);

   a_r3_first_is_ref: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_done && !ref_valid) |=> (in_sync && last_count == $past(meas_val)));

   a_r4_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !meas_done |=> $stable(last_count));

   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (on && sync_lost && !status_rd) |=> sync_lost);

   a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (on && status_rd && !meas_done) |=> !sync_lost);
endmodule

bind sync_lock_monitor syncmon_checker #(.CNT_W(CNT_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .sync_mode_en  (sync_mode_en),
   .ext_clk_en    (ext_clk_en),
   .pin_a_gpio_en (pin_a_gpio_en),
   .pin_b_gpio_en (pin_b_gpio_en),
   .rdy_strobe    (rdy_strobe),
   .status_rd     (status_rd),
   .in_sync       (in_sync),
   .sync_lost     (sync_lost),
   .last_count    (last_count),
   .armed         (armed),
   .cnt_val       (cnt_val),
   .meas_done     (meas_done),
   .meas_val      (meas_val),
   .ref_valid     (ref_valid)
);

// File: tb/tb_sync_lock_monitor.sv
`timescale 1ns/1ps
module tb_sync_lock_monitor;
   localparam int W = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sync_mode_en = 1'b0, ext_clk_en = 1'b0;
   logic pin_a_gpio_en = 1'b0, pin_b_gpio_en = 1'b0;
   logic rdy_strobe = 1'b0, sync_pin = 1'b0, status_rd = 1'b0;
   logic in_sync, sync_lost;
   logic [W-1:0] last_count;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   sync_lock_monitor #(.CNT_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .sync_mode_en(sync_mode_en), .ext_clk_en(ext_clk_en),
      .pin_a_gpio_en(pin_a_gpio_en), .pin_b_gpio_en(pin_b_gpio_en),
      .rdy_strobe(rdy_strobe), .sync_pin(sync_pin), .status_rd(status_rd),
      .in_sync(in_sync), .sync_lost(sync_lost), .last_count(last_count)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic expect_state(input string req, input int cnt, input bit s, input bit l);
      check(last_count == W'(cnt), req, int'(last_count), cnt);
      check(in_sync == s, req, int'(in_sync), int'(s));
      check(sync_lost == l, req, int'(sync_lost), int'(l));
   endtask

   // data-ready, then SYNC rising k cycles later: count = k+2
   task automatic do_meas(input int k);
      @(negedge clk) rdy_strobe = 1'b1;
      @(negedge clk) rdy_strobe = 1'b0;
      repeat (k - 1) @(negedge clk);
      sync_pin = 1'b1;
      repeat (4) @(negedge clk);
      sync_pin = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic pulse_read();
      @(negedge clk) status_rd = 1'b1;
      @(negedge clk) status_rd = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      expect_state("R1 reset", 0, 1'b0, 1'b0);
   endtask

   task automatic t_disabled();
      sync_mode_en = 1'b1; ext_clk_en = 1'b1; pin_b_gpio_en = 1'b1;
      do_meas(10);
      expect_state("R1 pin in gpio role", 0, 1'b0, 1'b0);
      pin_b_gpio_en = 1'b0; ext_clk_en = 1'b0;
      do_meas(10);
      expect_state("R1 ext clock off", 0, 1'b0, 1'b0);
      ext_clk_en = 1'b1;
   endtask

   task automatic t_reference();
      do_meas(10);
      expect_state("R2 R3 first measurement", 12, 1'b1, 1'b0);
      do_meas(10);
      expect_state("R4 equal measurement", 12, 1'b1, 1'b0);
   endtask

   task automatic t_tolerance();
      do_meas(11);
      expect_state("R5 plus one", 13, 1'b1, 1'b0);
      do_meas(9);
      expect_state("R5 minus one", 11, 1'b1, 1'b0);
   endtask

   task automatic t_loss();
      do_meas(13);
      expect_state("R6 plus three", 15, 1'b0, 1'b1);
      do_meas(13);
      expect_state("R7 flag sticky", 15, 1'b0, 1'b1);
      pulse_read();
      expect_state("R7 read clears", 15, 1'b1, 1'b0);
      do_meas(13);
      expect_state("R6 reference replaced", 15, 1'b1, 1'b0);
      do_meas(10);
      expect_state("R6 minus three", 12, 1'b0, 1'b1);
      pulse_read();
   endtask

   task automatic t_sync_only();
      @(negedge clk) sync_pin = 1'b1;
      repeat (4) @(negedge clk);
      sync_pin = 1'b0;
      repeat (4) @(negedge clk);
      expect_state("R9 sync without ready", 12, 1'b1, 1'b0);
   endtask

   task automatic t_double_ready();
      @(negedge clk) rdy_strobe = 1'b1;
      @(negedge clk) rdy_strobe = 1'b0;
      repeat (20) @(negedge clk);
      do_meas(10);
      expect_state("R10 latest ready counts", 12, 1'b1, 1'b0);
   endtask

   task automatic t_saturate();
      do_meas(80);
      expect_state("R8 saturates", 63, 1'b0, 1'b1);
      pulse_read();
   endtask

   task automatic t_reenable();
      @(negedge clk) sync_mode_en = 1'b0;
      repeat (2) @(negedge clk);
      check(in_sync == 1'b0 && sync_lost == 1'b0, "R1 disable clears", int'(in_sync), 0);
      sync_mode_en = 1'b1;
      do_meas(30);
      expect_state("R3 new reference after enable", 32, 1'b1, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_disabled();
      t_reference();
      t_tolerance();
      t_loss();
      t_sync_only();
      t_double_ready();
      t_saturate();
      t_reenable();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule